// File: doc/BRIEF.md
# E4 Byte-Alignment Frame Synchronizer

This block sits behind a byte-wide deserializer whose output bytes have an arbitrary bit phase relative to the E4 frame. Each clock it keeps the current input byte and the low seven bits of the previous one as a 15-bit sliding window. It compares all eight byte-wide slices of that window against the head of the E4 alignment word (0xFA) in the same cycle. When a slice matches, the block freezes on that offset and steers it into a registered output byte. From then on, whole bytes at the correct frame alignment come out.

The 12-bit alignment word is 1111 1010 0000. The head byte is found by the parallel compare, and the zero nibble is confirmed on the following byte at the frozen offset. A byte counter then predicts where the next word must appear, 366 bytes later. The frame-locked flag rises only after three consecutive good words at their predicted positions. Before lock, any failure drops the freeze at once and the hunt resumes. After lock, only four consecutive bad frames clear the lock and restart the hunt.

Top module: `e4_frame_aligner`

## Requirements
- R1: While reset is held, aligned_byte is 0x00, align_sel is 0, and head_found, tail_ok, align_hold and frame_locked are all 0.
- R2: During the hunt, when the 8-bit slice at offset k of the window equals 0xFA, the following outputs all appear together after the next clock edge: head_found pulses, align_sel equals k, aligned_byte equals 0xFA and align_hold is 1. Offset k means window bits 14-k down to 7-k, where window bits 14:8 are the previous byte's bits 6:0 and bits 7:0 are the current byte (bit 7 received first). align_sel does not change while align_hold stays high.
- R3: One cycle after head_found, tail_ok pulses if the next byte at the frozen offset has upper nibble 0000. In that case aligned_byte shows that byte.
- R4: While held, aligned_byte carries successive bytes of the stream at the frozen offset, one per clock.
- R5: After a confirmed word, the next word is expected exactly 366 bytes after the previous head, so consecutive head_found pulses in tracking are 366 cycles apart.
- R6: frame_locked rises on the same cycle as the third consecutive tail_ok, and not earlier.
- R7: Before lock, a failed nibble check clears align_hold on the following cycle, and the hunt over all offsets resumes.
- R8: Before lock, a missing 0xFA at the predicted position clears align_hold.
- R9: While locked, up to three consecutive frames with a missing or bad alignment word leave frame_locked and align_hold set. A good word resets the miss count.
- R10: While locked, the fourth consecutive bad frame clears frame_locked and align_hold. A later word at any offset is then acquired again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte | input | 8 | Unaligned byte from the deserializer, bit 7 first in time |
| aligned_byte | output | 8 | Registered byte at the selected offset |
| align_sel | output | 3 | Selected window offset 0..7 |
| head_found | output | 1 | One-cycle pulse: 0xFA accepted at the selected offset |
| tail_ok | output | 1 | One-cycle pulse: zero nibble confirmed after a head |
| align_hold | output | 1 | Offset is frozen (not hunting) |
| frame_locked | output | 1 | Frame synchronization declared |

## Verification
A wrong offset decode would show on the very head_found cycle: align_sel would differ from the offset set by the stimulus phase, and aligned_byte would not read 0xFA. A byte counter that is off by even one position moves the next head_found away from the 366-cycle spacing. It also lets the word be missed, so align_hold drops about one frame later. Faults in the good and miss counters show up at frame granularity. frame_locked then rises on the wrong tail_ok, survives a fourth bad frame, or drops after the third.

// File: rtl/e4_sync_pkg.sv
package e4_sync_pkg;
    // Head byte of the 12-bit alignment word; the tail is a zero nibble.
    localparam logic [7:0] ALIGN_HEAD = 8'hFA;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_TRACK   = 2'd2
    } sync_st_e;
endpackage

// File: rtl/e4_offset_scan.sv
module e4_offset_scan
    import e4_sync_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     din,
    output logic [2*W-2:0]   win,
    output logic [W-1:0]     hits
);
    logic [2*W-2:0] win_d, win_q;

    always_comb begin
        win_d = {win_q[W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign win = win_q;

    // one comparator per offset, all evaluated in the same cycle
    for (genvar k = 0; k < W; k++) begin : g_cmp
        assign hits[k] = (win_q[2*W-2-k -: W] == ALIGN_HEAD);
    end
endmodule

// File: rtl/e4_byte_pick.sv
module e4_byte_pick #(
    parameter int W     = 8,
    parameter int SEL_W = $clog2(W)
) (
    input  logic [2*W-2:0]   win,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     byte_o
);
    // bit i of the byte at offset k is window bit (W-1-k+i)
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [W-1:0] cand;
        for (genvar k = 0; k < W; k++) begin : g_off
            assign cand[k] = win[W-1-k+i];
        end
        assign byte_o[i] = cand[sel];
    end
endmodule

// File: rtl/e4_sync_ctrl.sv
module e4_sync_ctrl
    import e4_sync_pkg::*;
#(
    parameter int W           = 8,
    parameter int SEL_W       = $clog2(W),
    parameter int FRAME_BYTES = 366,
    parameter int GOOD_NEED   = 3,
    parameter int MISS_LIMIT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     hits,
    input  logic [W-1:0]     cur_byte,
    output logic [SEL_W-1:0] sel_q_o,
    output logic [SEL_W-1:0] sel_nx_o,
    output logic             hold_o,
    output logic             sync_o,
    output logic             head_o,
    output logic             tail_o
);
    localparam int CNT_W = $clog2(FRAME_BYTES);
    localparam int GW    = $clog2(GOOD_NEED + 1);
    localparam int MW    = $clog2(MISS_LIMIT + 1);
    localparam logic [CNT_W-1:0] RELOAD_TAIL = CNT_W'(FRAME_BYTES - 2);
    localparam logic [CNT_W-1:0] RELOAD_HEAD = CNT_W'(FRAME_BYTES - 1);
    localparam logic [GW-1:0]    GOOD_LAST   = GW'(GOOD_NEED - 1);
    localparam logic [MW-1:0]    MISS_LAST   = MW'(MISS_LIMIT - 1);

    typedef struct packed {
        sync_st_e         st;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
        logic [GW-1:0]    good;
        logic [MW-1:0]    miss;
        logic             sync;
        logic             head;
        logic             tail;
    } ctl_t;

    ctl_t q, n;
    logic [SEL_W-1:0] first;
    logic             miss_now;
    logic [CNT_W-1:0] reload;

    always_comb begin
        n        = q;
        n.head   = 1'b0;
        n.tail   = 1'b0;
        miss_now = 1'b0;
        reload   = RELOAD_TAIL;

        // lowest-numbered matching offset wins
        first = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (hits[k]) first = SEL_W'(k);
        end

        case (q.st)
            ST_HUNT: begin
                if (|hits) begin
                    n.st   = ST_CONFIRM;
                    n.sel  = first;
                    n.head = 1'b1;
                end
            end
            ST_CONFIRM: begin
                if (cur_byte[W-1 -: W/2] == '0) begin
                    n.tail = 1'b1;
                    n.miss = '0;
                    n.st   = ST_TRACK;
                    n.cnt  = RELOAD_TAIL;
                    if (!q.sync) begin
                        if (q.good == GOOD_LAST) n.sync = 1'b1;
                        else                     n.good = q.good + 1'b1;
                    end
                end else begin
                    miss_now = 1'b1;
                    reload   = RELOAD_TAIL;
                end
            end
            ST_TRACK: begin
                if (q.cnt != '0) begin
                    n.cnt = q.cnt - 1'b1;
                end else if (hits[q.sel]) begin
                    n.st   = ST_CONFIRM;
                    n.head = 1'b1;
                end else begin
                    miss_now = 1'b1;
                    reload   = RELOAD_HEAD;
                end
            end
            default: n.st = ST_HUNT;
        endcase

        if (miss_now) begin
            if (!q.sync || q.miss == MISS_LAST) begin
                n.st   = ST_HUNT;
                n.sync = 1'b0;
                n.good = '0;
                n.miss = '0;
            end else begin
                n.miss = q.miss + 1'b1;
                n.st   = ST_TRACK;
                n.cnt  = reload;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_HUNT;
            q.sel  <= '0;
            q.cnt  <= '0;
            q.good <= '0;
            q.miss <= '0;
            q.sync <= 1'b0;
            q.head <= 1'b0;
            q.tail <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign sel_q_o  = q.sel;
    assign sel_nx_o = n.sel;
    assign hold_o   = (q.st != ST_HUNT);
    assign sync_o   = q.sync;
    assign head_o   = q.head;
    assign tail_o   = q.tail;
endmodule

// File: rtl/e4_frame_aligner.sv
module e4_frame_aligner
    import e4_sync_pkg::*;
#(
    parameter int FRAME_BYTES = 366,
    parameter int GOOD_NEED   = 3,
    parameter int MISS_LIMIT  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rx_byte,
    output logic [7:0] aligned_byte,
    output logic [2:0] align_sel,
    output logic       head_found,
    output logic       tail_ok,
    output logic       align_hold,
    output logic       frame_locked
);
    localparam int W     = $bits(ALIGN_HEAD);
    localparam int SEL_W = $clog2(W);

    logic [2*W-2:0]   win;
    logic [W-1:0]     hits;
    logic [W-1:0]     cur_byte;
    logic [W-1:0]     next_byte;
    logic [SEL_W-1:0] sel_q, sel_nx;
    logic [W-1:0]     out_d, out_q;

    e4_offset_scan #(.W(W)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_byte),
        .win   (win),
        .hits  (hits)
    );

    // slice at the frozen offset, used for the nibble check
    e4_byte_pick #(.W(W), .SEL_W(SEL_W)) u_pick_chk (
        .win    (win),
        .sel    (sel_q),
        .byte_o (cur_byte)
    );

    // slice at the next offset, so the head byte itself reaches the output
    e4_byte_pick #(.W(W), .SEL_W(SEL_W)) u_pick_out (
        .win    (win),
        .sel    (sel_nx),
        .byte_o (next_byte)
    );

    e4_sync_ctrl #(
        .W           (W),
        .SEL_W       (SEL_W),
        .FRAME_BYTES (FRAME_BYTES),
        .GOOD_NEED   (GOOD_NEED),
        .MISS_LIMIT  (MISS_LIMIT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hits     (hits),
        .cur_byte (cur_byte),
        .sel_q_o  (sel_q),
        .sel_nx_o (sel_nx),
        .hold_o   (align_hold),
        .sync_o   (frame_locked),
        .head_o   (head_found),
        .tail_o   (tail_ok)
    );

    always_comb begin
        out_d = next_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign aligned_byte = out_q;
    assign align_sel    = sel_q;
endmodule

// File: rtl/e4_sync_chk.sv
module e4_sync_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] align_sel,
    input logic       head_found,
    input logic       tail_ok,
    input logic       align_hold,
    input logic       frame_locked
);
    // R2
    head_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head_found |-> align_hold);

    // R2
    sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (align_hold && $past(align_hold)) |-> $stable(align_sel));

    // R3
    tail_after_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tail_ok |-> $past(head_found));

    // R6
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_locked) |-> tail_ok);

    // R9
    lock_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_locked |-> align_hold);

    // R10
    lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_locked) |-> !align_hold);
endmodule

bind e4_frame_aligner e4_sync_chk u_sync_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .align_sel    (align_sel),
    .head_found   (head_found),
    .tail_ok      (tail_ok),
    .align_hold   (align_hold),
    .frame_locked (frame_locked)
);

// File: tb/sim_e4_frame_aligner.sv
module sim_e4_frame_aligner;
    localparam int FRAME_BITS = 2928;
    localparam int FRAME_BY   = 366;
    localparam logic [11:0] WORD = 12'b1111_1010_0000;
    localparam int N_ROWS = 8;
    // stimulus: stream phase in bits; expected: offset that must be chosen
    localparam int ROW_PHASE [N_ROWS] = '{0, 3, 250, 1777, 2925, 2927, 2926, 4};
    localparam int ROW_SEL   [N_ROWS] = '{7, 4, 5, 6, 2, 0, 1, 3};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] aligned_byte;
    logic [2:0] align_sel;
    logic       head_found, tail_ok, align_hold, frame_locked;

    int n_chk = 0, n_bad = 0;
    int phase = 0, kill_lo = -1, kill_hi = -2, bad_nib = -1;
    int bidx = 0;
    logic [7:0] s_dout;
    logic [2:0] s_sel;
    logic s_head, s_tail, s_hold, s_lock;

    always #4 clk = ~clk;

    e4_frame_aligner u0 (
        .clk (clk), .rst_n (rst_n), .rx_byte (din),
        .aligned_byte (aligned_byte), .align_sel (align_sel),
        .head_found (head_found), .tail_ok (tail_ok),
        .align_hold (align_hold), .frame_locked (frame_locked)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic bit_at(int g);
        int p = (g + phase) % FRAME_BITS;
        int f = (g + phase) / FRAME_BITS;
        bit killed = (f >= kill_lo) && (f <= kill_hi);
        if (p < 12 && !killed) begin
            if (p == 8 && f == bad_nib) return 1'b1;
            return WORD[11-p];
        end
        return logic'(p % 2);
    endfunction

    function automatic logic [7:0] byte_at(int j);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[7-i] = bit_at(8*j + i);
        return b;
    endfunction

    task automatic tick();
        @(negedge clk);
        s_dout = aligned_byte; s_sel = align_sel; s_head = head_found;
        s_tail = tail_ok; s_hold = align_hold; s_lock = frame_locked;
        din = byte_at(bidx);
        bidx++;
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0;
        din = 8'h00;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk(aligned_byte == 8'h00 && align_sel == 3'd0, "R1 data/sel", {aligned_byte, 5'b0, align_sel}, 0);
        chk({head_found, tail_ok, align_hold, frame_locked} == 4'b0, "R1 flags",
            {head_found, tail_ok, align_hold, frame_locked}, 0);
        rst_n = 1'b1;
        din = byte_at(0);
        bidx = 1;
    endtask

    task automatic wait_head(output int n);
        n = 0;
        do begin tick(); n++; end while (!s_head && n < 800);
    endtask

    task automatic until_bit(input int g);
        while (8*bidx < g) tick();
    endtask

    function automatic int frame_now();
        return (8*(bidx-1) + phase) / FRAME_BITS;
    endfunction

    initial begin
        int n;
        int f;
        // table walk: every offset acquired, confirmed, tracked and locked
        for (int r = 0; r < N_ROWS; r++) begin
            phase = ROW_PHASE[r]; kill_lo = -1; kill_hi = -2; bad_nib = -1;
            reset_dut();
            wait_head(n);
            chk(s_head, "R2 head found", s_head, 1);
            chk(s_sel == 3'(ROW_SEL[r]), "R2 offset", s_sel, ROW_SEL[r]);
            chk(s_dout == 8'hFA && s_hold, "R2 head byte/hold", s_dout, 8'hFA);
            tick();
            chk(s_tail && s_dout == 8'h05, "R3 tail", {s_tail, s_dout}, {1'b1, 8'h05});
            tick();
            chk(s_dout == 8'h55, "R4 aligned payload", s_dout, 8'h55);
            wait_head(n);
            chk(n + 2 == FRAME_BY, "R5 frame spacing", n + 2, FRAME_BY);
            tick();
            chk(s_tail && !s_lock, "R6 no lock at second", {s_tail, s_lock}, 2'b10);
            wait_head(n);
            tick();
            chk(s_tail && s_lock, "R6 lock at third", {s_tail, s_lock}, 2'b11);
        end

        // R7: bad nibble before lock
        phase = 500; kill_lo = -1; kill_hi = -2; bad_nib = 2;
        reset_dut();
        wait_head(n); tick();
        chk(s_tail, "R7 first tail", s_tail, 1);
        wait_head(n); tick();
        chk(!s_tail && !s_hold && !s_lock, "R7 hold released", {s_tail, s_hold, s_lock}, 0);
        wait_head(n);
        chk(s_head && s_sel == 3'd3, "R7 reacquire", s_sel, 3);

        // R8: missing head at predicted position before lock
        phase = 900; kill_lo = 2; kill_hi = 2; bad_nib = -1;
        reset_dut();
        wait_head(n); tick();
        until_bit(2*FRAME_BITS - phase + 400);
        chk(!s_hold && !s_lock, "R8 hold released", {s_hold, s_lock}, 0);

        // R9 / R10: misses after lock
        phase = 40; kill_lo = -1; kill_hi = -2; bad_nib = -1;
        reset_dut();
        for (int k = 0; k < 3; k++) begin wait_head(n); tick(); end
        chk(s_lock, "R9 locked", s_lock, 1);
        f = frame_now();
        kill_lo = f + 1; kill_hi = f + 3;
        until_bit((f + 3)*FRAME_BITS - phase + 800);
        chk(s_lock && s_hold, "R9 three misses kept", {s_lock, s_hold}, 2'b11);
        until_bit((f + 4)*FRAME_BITS - phase + 800);
        chk(s_lock && s_hold, "R9 recovered word", {s_lock, s_hold}, 2'b11);
        kill_lo = f + 5; kill_hi = f + 8;
        until_bit((f + 7)*FRAME_BITS - phase + 800);
        chk(s_lock, "R9 third miss still locked", s_lock, 1);
        until_bit((f + 8)*FRAME_BITS - phase + 800);
        chk(!s_lock && !s_hold, "R10 fourth miss drops", {s_lock, s_hold}, 0);
        wait_head(n);
        chk(s_head && s_sel == 3'd7, "R10 reacquire", s_sel, 7);

        reset_dut();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule